// File: doc/BRIEF.md
# Core Voltage Window Monitor

This block watches a digitised core-supply reading and decides whether the rail is healthy. Each time a new measurement word is strobed in, it is compared with four thresholds. All four are fixed ratios of a target word. From these comparisons the block keeps an under-voltage flag and an over-voltage latch. It drives a power-good output, and it sends a request to the PWM stage: run normally, clamp the low-side switches, or float the outputs.

Under-voltage uses separate thresholds for falling and for rising voltage. It only pulls power-good down. Over-voltage sets a latch that only the power-on reset clears. While latched, the block acts as a hysteretic shunt. It asks for the low clamp while the rail is above the upper limit, and it asks for three-state once the rail has dropped below a slightly lower limit. It keeps cycling between the two as the rail moves.

Top module: `vcore_window_mon`

## Requirements
- R1: While `por_n` is low and after its release, `pwr_good` is 0, `ov_latched` is 0 and `pwm_req` is 2'b00 (run). The under-voltage flag resets to set.
- R2: With t the target, thresholds use truncated right shifts: fall = t-(t>>4)-(t>>5)-(t>>8)-(t>>9), rise = t-(t>>4)-(t>>6)-(t>>9), over = t+(t>>3)+(t>>6)+(t>>7)+(t>>10), release = t+(t>>3)+(t>>8)+(t>>10).
- R3: A measurement is taken at each rising edge with `meas_vld` high. A condition acts only when the last two samples taken both meet it. The outputs then change at the first clock edge after the second of those samples.
- R4: Two consecutive samples strictly below fall set the under-voltage flag.
- R5: Two consecutive samples at or above rise clear the under-voltage flag. Samples between fall and rise leave it unchanged.
- R6: `pwr_good` = `ss_done` AND no under-voltage AND not `ov_latched`. It follows `ss_done` in the same cycle.
- R7: The under-voltage flag has no effect on `ov_latched` or `pwm_req`.
- R8: Two consecutive samples strictly above over set `ov_latched` and switch `pwm_req` to 2'b01 (low clamp), which forces `pwr_good` low.
- R9: Once set, `ov_latched` stays at 1 until `por_n` goes low, whatever the measurement does.
- R10: While latched, two consecutive samples strictly below release give `pwm_req` 2'b10 (three-state). Two consecutive samples above over give 2'b01 again. Samples in between hold the request. 2'b11 never appears.
- R11: A single out-of-range sample that is not followed by a matching sample changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| meas_vld | input | 1 | Sample strobe for `meas_code` |
| meas_code | input | W | Measured rail voltage code |
| tgt_code | input | W | Programmed target voltage code |
| ss_done | input | 1 | Soft-start sequence has finished |
| pwr_good | output | 1 | Rail in window and soft-start done |
| ov_latched | output | 1 | Over-voltage latch |
| pwm_req | output | 2 | 00 run, 01 low clamp, 10 three-state |

## Verification
On every cycle, the assertions check these relations:
- the over-voltage latch never falls outside reset;
- power-good never coexists with the latch or with soft-start not done;
- a latched block never requests normal run;
- the request code stays legal;
- the latch and the request hold still unless a sample was taken two cycles earlier.

Some behaviour depends on the actual values and can only be shown by the bench's scenarios, which the behavioural model checks every clock:
- the exact threshold arithmetic;
- the rising and falling under-voltage hysteresis;
- the two-sample persistence, including with gaps between strobes;
- the rejection of isolated glitches;
- the clamp and three-state cycling.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  typedef enum logic [1:0] {
    REQ_RUN   = 2'b00,
    REQ_CLAMP = 2'b01,
    REQ_TRI   = 2'b10
  } vwm_req_e;

  localparam int unsigned FRAC_BITS = 10;
  // shift-term masks, bit i selects t>>i
  localparam logic [FRAC_BITS:1] MASK_FALL = 10'b0110011000; // 4,5,8,9
  localparam logic [FRAC_BITS:1] MASK_RISE = 10'b0100101000; // 4,6,9
  localparam logic [FRAC_BITS:1] MASK_OVER = 10'b1001100100; // 3,6,7,10
  localparam logic [FRAC_BITS:1] MASK_REL  = 10'b1010000100; // 3,8,10
endpackage

// File: rtl/vwm_ratio.sv
module vwm_ratio #(
  parameter int unsigned W = 10,
  parameter int unsigned FRAC = 10,
  parameter bit SUB = 1'b0,
  parameter logic [FRAC:1] MASK = '0
) (
  input  logic [W-1:0] tgt,
  output logic [W:0]   thr
);
  localparam int unsigned OW = W + 1;

  logic [OW-1:0] term [FRAC:1];
  logic [OW-1:0] acc;

  for (genvar i = 1; i <= FRAC; i++) begin : g_term
    if (MASK[i]) begin : g_on
      assign term[i] = OW'(tgt >> i);
    end else begin : g_off
      assign term[i] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 1; k <= FRAC; k++) begin
      acc = acc + term[k];
    end
  end

  if (SUB) begin : g_sub
    assign thr = OW'(tgt) - acc;
  end else begin : g_add
    assign thr = OW'(tgt) + acc;
  end
endmodule

// File: rtl/vwm_persist.sv
module vwm_persist (
  input  logic clk,
  input  logic por_n,
  input  logic smp_en,
  input  logic cond,
  output logic hit
);
  logic cmp_q, cmp_qq;
  logic cmp_d, cmp_dd;

  always_comb begin
    cmp_d  = cmp_q;
    cmp_dd = cmp_qq;
    if (smp_en) begin
      cmp_d  = cond;
      cmp_dd = cmp_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cmp_q  <= 1'b0;
      cmp_qq <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      cmp_qq <= cmp_dd;
    end
  end

  assign hit = cmp_q & cmp_qq;
endmodule

// File: rtl/vwm_ovctl.sv
module vwm_ovctl
  import vwm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       hit_over,
  input  logic       hit_rel,
  output logic       ov_lat,
  output logic [1:0] req
);
  logic     lat_q, lat_d;
  vwm_req_e req_q, req_d;

  always_comb begin
    lat_d = lat_q;
    req_d = req_q;
    if (!lat_q) begin
      if (hit_over) begin
        lat_d = 1'b1;
        req_d = REQ_CLAMP;
      end
    end else begin
      if (hit_over) begin
        req_d = REQ_CLAMP;
      end else if (hit_rel) begin
        req_d = REQ_TRI;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lat_q <= 1'b0;
      req_q <= REQ_RUN;
    end else begin
      lat_q <= lat_d;
      req_q <= req_d;
    end
  end

  assign ov_lat = lat_q;
  assign req    = req_q;
endmodule

// File: rtl/vcore_window_mon.sv
module vcore_window_mon
  import vwm_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         meas_vld,
  input  logic [W-1:0] meas_code,
  input  logic [W-1:0] tgt_code,
  input  logic         ss_done,
  output logic         pwr_good,
  output logic         ov_latched,
  output logic [1:0]   pwm_req
);
  localparam int unsigned NCMP = 4;
  localparam int unsigned C_FALL = 0;
  localparam int unsigned C_RISE = 1;
  localparam int unsigned C_OVER = 2;
  localparam int unsigned C_REL  = 3;

  logic [W:0] thr_fall, thr_rise, thr_over, thr_rel;
  logic [W:0] meas_x;
  logic [NCMP-1:0] cond, hit;
  logic uv_q, uv_d;

  vwm_ratio #(.W(W), .FRAC(FRAC_BITS), .SUB(1'b1), .MASK(MASK_FALL))
    u_thr_fall (.tgt(tgt_code), .thr(thr_fall));
  vwm_ratio #(.W(W), .FRAC(FRAC_BITS), .SUB(1'b1), .MASK(MASK_RISE))
    u_thr_rise (.tgt(tgt_code), .thr(thr_rise));
  vwm_ratio #(.W(W), .FRAC(FRAC_BITS), .SUB(1'b0), .MASK(MASK_OVER))
    u_thr_over (.tgt(tgt_code), .thr(thr_over));
  vwm_ratio #(.W(W), .FRAC(FRAC_BITS), .SUB(1'b0), .MASK(MASK_REL))
    u_thr_rel  (.tgt(tgt_code), .thr(thr_rel));

  assign meas_x = {1'b0, meas_code};

  always_comb begin
    cond[C_FALL] = meas_x <  thr_fall;
    cond[C_RISE] = meas_x >= thr_rise;
    cond[C_OVER] = meas_x >  thr_over;
    cond[C_REL]  = meas_x <  thr_rel;
  end

  for (genvar c = 0; c < NCMP; c++) begin : g_pers
    vwm_persist u_pers (
      .clk   (clk),
      .por_n (por_n),
      .smp_en(meas_vld),
      .cond  (cond[c]),
      .hit   (hit[c])
    );
  end

  // under-voltage flag with rising/falling hysteresis
  always_comb begin
    uv_d = uv_q;
    if (hit[C_FALL]) begin
      uv_d = 1'b1;
    end else if (hit[C_RISE]) begin
      uv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      uv_q <= 1'b1;
    end else begin
      uv_q <= uv_d;
    end
  end

  vwm_ovctl u_ovctl (
    .clk     (clk),
    .por_n   (por_n),
    .hit_over(hit[C_OVER]),
    .hit_rel (hit[C_REL]),
    .ov_lat  (ov_latched),
    .req     (pwm_req)
  );

  assign pwr_good = ss_done & ~uv_q & ~ov_latched;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker (
  input logic       clk,
  input logic       por_n,
  input logic       meas_vld,
  input logic       ss_done,
  input logic       pwr_good,
  input logic       ov_latched,
  input logic [1:0] pwm_req
);
  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ov_latched |=> ov_latched); // R9
  AST_PG_NEEDS_SS: assert property (@(posedge clk) disable iff (!por_n)
    pwr_good |-> ss_done); // R6
  AST_PG_LOW_ON_OV: assert property (@(posedge clk) disable iff (!por_n)
    ov_latched |-> !pwr_good); // R8
  AST_OV_ENTERS_CLAMP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ov_latched) |-> pwm_req == 2'b01); // R8
  AST_NO_RUN_WHEN_OV: assert property (@(posedge clk) disable iff (!por_n)
    ov_latched |-> pwm_req != 2'b00); // R10
  AST_REQ_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
    pwm_req != 2'b11); // R10
  AST_QUIET_OV: assert property (@(posedge clk) disable iff (!por_n)
    !$past(meas_vld, 2) |-> $stable(ov_latched)); // R3
  AST_QUIET_REQ: assert property (@(posedge clk) disable iff (!por_n)
    !$past(meas_vld, 2) |-> $stable(pwm_req)); // R3
endmodule

bind vcore_window_mon vwm_checker u_vwm_checker (
  .clk       (clk),
  .por_n     (por_n),
  .meas_vld  (meas_vld),
  .ss_done   (ss_done),
  .pwr_good  (pwr_good),
  .ov_latched(ov_latched),
  .pwm_req   (pwm_req)
);

// File: tb/test_vcore_window_mon.sv
`timescale 1ns/1ps
module test_vcore_window_mon;
  localparam int W = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic meas_vld = 1'b0;
  logic [W-1:0] meas_code = '0;
  logic [W-1:0] tgt_code = 10'd800;
  logic ss_done = 1'b0;
  logic pwr_good, ov_latched;
  logic [1:0] pwm_req;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcore_window_mon #(.W(W)) i_vcore_window_mon (
    .clk(clk), .por_n(por_n), .meas_vld(meas_vld), .meas_code(meas_code),
    .tgt_code(tgt_code), .ss_done(ss_done), .pwr_good(pwr_good),
    .ov_latched(ov_latched), .pwm_req(pwm_req)
  );

  // thresholds from R2
  function automatic int th_fall(int t); return t-(t>>4)-(t>>5)-(t>>8)-(t>>9); endfunction
  function automatic int th_rise(int t); return t-(t>>4)-(t>>6)-(t>>9); endfunction
  function automatic int th_over(int t); return t+(t>>3)+(t>>6)+(t>>7)+(t>>10); endfunction
  function automatic int th_rel(int t);  return t+(t>>3)+(t>>8)+(t>>10); endfunction

  // behavioural reference: history of classified samples
  typedef struct { bit lo; bit hi; bit ov; bit rl; } cls_t;
  cls_t hist[$];
  bit m_uv = 1'b1;
  bit m_ov = 1'b0;
  int m_req = 0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_uv = 1'b1; m_ov = 1'b0; m_req = 0; hist.delete();
    end else begin
      if (hist.size() == 2) begin
        if (hist[0].lo && hist[1].lo) m_uv = 1'b1;
        else if (hist[0].hi && hist[1].hi) m_uv = 1'b0;
        if (hist[0].ov && hist[1].ov) begin m_ov = 1'b1; m_req = 1; end
        else if (m_ov && hist[0].rl && hist[1].rl) m_req = 2;
      end
      if (meas_vld) begin
        cls_t c;
        int v, t;
        v = int'(meas_code); t = int'(tgt_code);
        c.lo = v < th_fall(t); c.hi = v >= th_rise(t);
        c.ov = v > th_over(t); c.rl = v < th_rel(t);
        hist.push_back(c);
        if (hist.size() > 2) void'(hist.pop_front());
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (por_n && !done) begin
      chk(cur_req, int'(pwr_good), int'(ss_done && !m_uv && !m_ov), "pwr_good");
      chk(cur_req, int'(ov_latched), int'(m_ov), "ov_latched");
      chk(cur_req, int'(pwm_req), m_req, "pwm_req");
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(int v, int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); meas_code = W'(v); meas_vld = 1'b1;
      @(negedge clk); meas_vld = 1'b0;
      idle(gap);
    end
    idle(2);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int t;
    t = 800;
    idle(3);
    cur_req = "R1";
    chk("R1", int'(pwr_good), 0, "pwr_good in reset");
    chk("R1", int'(ov_latched), 0, "ov in reset");
    chk("R1", int'(pwm_req), 0, "req in reset");
    @(negedge clk); por_n = 1'b1;
    idle(2);
    chk("R1", int'(pwm_req), 0, "req after release");
    ss_done = 1'b1;
    chk("R1", int'(pwr_good), 0, "uv set after reset");

    cur_req = "R5";
    send(t, 2, 0);
    chk("R5", int'(pwr_good), 1, "uv cleared at target");
    chk("R2", th_fall(t), 721, "fall threshold");

    cur_req = "R11";
    send(th_fall(t) - 1, 1, 0);
    send(t, 1, 0);
    chk("R11", int'(pwr_good), 1, "glitch ignored");

    cur_req = "R4";
    send(th_fall(t) - 1, 2, 0);
    chk("R4", int'(pwr_good), 0, "uv asserted");
    chk("R7", int'(pwm_req), 0, "uv leaves req");
    chk("R7", int'(ov_latched), 0, "uv leaves ov");

    cur_req = "R5";
    send(th_fall(t), 2, 0);
    chk("R5", int'(pwr_good), 0, "at fall threshold holds uv");
    send(th_rise(t) - 1, 2, 3);
    chk("R5", int'(pwr_good), 0, "hysteresis band holds uv");
    send(th_rise(t), 2, 3);
    chk("R5", int'(pwr_good), 1, "rise threshold clears with gaps");

    cur_req = "R6";
    @(negedge clk); ss_done = 1'b0; #1;
    chk("R6", int'(pwr_good), 0, "ss_done low");
    @(negedge clk); ss_done = 1'b1; #1;
    chk("R6", int'(pwr_good), 1, "ss_done high");

    cur_req = "R3";
    @(negedge clk); meas_code = W'(th_over(t) + 1); meas_vld = 1'b1;
    @(negedge clk); meas_vld = 1'b1;
    @(negedge clk); meas_vld = 1'b0;
    chk("R3", int'(ov_latched), 0, "no change before next edge");
    @(negedge clk);
    chk("R3", int'(ov_latched), 1, "change one edge after second sample");
    chk("R8", int'(pwm_req), 1, "clamp on ov");
    chk("R8", int'(pwr_good), 0, "pg low on ov");

    cur_req = "R10";
    send(th_rel(t), 2, 0);
    chk("R10", int'(pwm_req), 1, "band holds clamp");
    send(th_rel(t) - 1, 2, 0);
    chk("R10", int'(pwm_req), 2, "three-state below release");
    send(th_over(t), 2, 0);
    chk("R10", int'(pwm_req), 2, "at over threshold holds");
    send(th_over(t) + 1, 2, 1);
    chk("R10", int'(pwm_req), 1, "clamp again");

    cur_req = "R9";
    send(t, 3, 0);
    chk("R9", int'(ov_latched), 1, "latch persists at target");
    chk("R9", int'(pwm_req), 2, "three-state at target");
    chk("R9", int'(pwr_good), 0, "pg stays low");

    cur_req = "R1";
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    chk("R9", int'(ov_latched), 0, "reset clears latch");
    tgt_code = 10'd600;
    @(negedge clk); por_n = 1'b1;
    cur_req = "R2";
    t = 600;
    send(th_over(t) + 1, 2, 0);
    chk("R2", int'(ov_latched), 1, "over threshold new target");
    idle(3);
    finish_run();
  end
endmodule